// File: doc/BRIEF.md
# Pipelined Store Path for a Direct-Mapped Data Cache

This block is the front end of a small direct-mapped data cache with one word per line. Stores pass through two stages. The tag is checked in the cycle a store is accepted. The data array is written later, in the cycle when the next store is accepted, so one store's array update overlaps the next store's tag check. A store that has passed its tag check waits in a single-entry pending-store register that holds its address, data and byte enables. Every load compares its address with that register. On a match, the pending bytes are merged over the word read from the array. Loads never take a slot in the update stage.

A request that misses (load or store) stops the CPU port. The pending store is written to the array first. Then one request goes out on the refill port, and the block waits for the single-word fill. A missed load returns the fill word. A missed store installs the line and then becomes the pending store. The pending store is also written back to the array on its own after a run of cycles with no store. The length of that run is set by a 2-bit input, from 1 to 4 cycles. Lines that are replaced are overwritten without being written out.

Top module: `pipelined_store_cache`

## Requirements
- R1: After reset, cpu_ready is 1, rsp_valid and miss_valid are 0, and every line is invalid, so the first access to any address misses.
- R2: A load that hits is accepted on the clock edge where cpu_valid and cpu_ready are both 1. rsp_valid is 1 with the word after the second edge from acceptance and 0 after the first. While cpu_ready stays 1, a new request is accepted on every edge.
- R3: A store that hits is accepted without any stall. Stores to lines that are present can be accepted on consecutive edges. Each one replaces the pending store, and the replaced store is written to the array in that same cycle.
- R4: A load whose full word address equals the pending store's address returns, for each byte lane, the pending byte where that lane's enable is 1 and the array byte where it is 0.
- R5: On a miss, cpu_ready is 0 after the accepting edge. The pending store is written to the array before miss_valid rises. miss_valid and miss_addr (the word address of the missing request) stay stable until an edge where fill_valid is 1.
- R6: For a load miss, the edge that takes the fill installs the line and raises rsp_valid with fill_data for one cycle. cpu_ready returns to 1 after that edge, and later loads to the address hit.
- R7: For a store miss, the edge that takes the fill installs the line with fill_data, and the store becomes the pending store. A later load returns the store's enabled bytes over the fill word.
- R8: The pending store is written to the array and released after idle_sel+1 consecutive cycles in which no store is accepted (idle_sel = 0..3).
- R9: The data array receives at most one write per cycle. A fill write and a pending-store write never coincide.
- R10: Byte lane i of cpu_be covers cpu_wdata bits 8i+7 down to 8i. Lanes whose enable is 0 keep their previous value. The address is a word address: the low INDEX_W bits select the line and the rest form the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_sel | input | 2 | Idle cycles before the pending store is released, minus one |
| cpu_valid | input | 1 | Request present |
| cpu_ready | output | 1 | Block can accept a request (registered) |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_be | input | DATA_W/8 | Store byte enables |
| rsp_valid | output | 1 | Load data valid (one cycle) |
| rsp_data | output | DATA_W | Load data |
| miss_valid | output | 1 | Refill request pending |
| miss_addr | output | ADDR_W | Word address to refill |
| fill_valid | input | 1 | Refill word present |
| fill_data | input | DATA_W | Refill word |

## Verification
Properties checked on every cycle: the port stays stalled while a refill is outstanding, the refill request holds until its fill arrives, the pending store is empty during a miss, the pending store never outlives the programmed idle run, and the array never takes two writes in one cycle. Only the bench scenarios can show that data is correct. This covers byte-lane merging of a pending store over array data, the ordering of back-to-back stores and the write they push into the array, store-miss installation, the effect of evicting lines, and the exact response latency. The bench checks these against a line-level model of a direct-mapped cache with no write-back.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_WAIT  = 2'd2
  } psc_state_e;
endpackage

// File: rtl/psc_tag_store.sv
module psc_tag_store #(
  parameter int INDEX_W = 4,
  parameter int TAG_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INDEX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0]   lk_tag,
  output logic               lk_hit,
  input  logic               wr_en,
  input  logic [INDEX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0]   wr_tag
);
  localparam int LINES = 1 << INDEX_W;

  logic [TAG_W-1:0] tags [LINES];
  logic [LINES-1:0] present;

  always_ff @(posedge clk) begin
    if (rst) present <= '0;
    else if (wr_en) present[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tags[wr_idx] <= wr_tag;
  end

  assign lk_hit = present[lk_idx] && (tags[lk_idx] == lk_tag);
endmodule

// File: rtl/psc_data_ram.sv
module psc_data_ram #(
  parameter int INDEX_W = 4,
  parameter int DATA_W  = 32
) (
  input  logic                clk,
  input  logic                rd_en,
  input  logic [INDEX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                wr_en,
  input  logic [INDEX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [DATA_W/8-1:0] wr_be
);
  localparam int LINES = 1 << INDEX_W;
  localparam int LANES = DATA_W / 8;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [7:0] lane_mem [LINES];
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (wr_en && wr_be[b]) lane_mem[wr_idx] <= wr_data[b*8 +: 8];
      if (rd_en) lane_q <= lane_mem[rd_idx];
    end
    assign rd_data[b*8 +: 8] = lane_q;
  end
endmodule

// File: rtl/psc_write_buf.sv
module psc_write_buf #(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          idle_sel,
  input  logic                push,
  input  logic [ADDR_W-1:0]   push_addr,
  input  logic [DATA_W-1:0]   push_data,
  input  logic [DATA_W/8-1:0] push_be,
  input  logic                flush,
  input  logic [ADDR_W-1:0]   look_addr,
  output logic [DATA_W/8-1:0] look_be,
  output logic                q_valid,
  output logic [INDEX_W-1:0]  q_idx,
  output logic [DATA_W-1:0]   q_data,
  output logic [DATA_W/8-1:0] q_be,
  output logic                retire
);
  logic [ADDR_W-1:0] q_addr;
  logic [1:0]        idle_cnt;

  assign retire = q_valid && (push || flush || (idle_cnt == idle_sel));

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid  <= 1'b0;
      idle_cnt <= '0;
    end else if (push) begin
      q_valid  <= 1'b1;
      idle_cnt <= '0;
    end else if (retire) begin
      q_valid  <= 1'b0;
    end else if (q_valid) begin
      idle_cnt <= idle_cnt + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      q_addr <= push_addr;
      q_data <= push_data;
      q_be   <= push_be;
    end
  end

  assign q_idx   = q_addr[INDEX_W-1:0];
  assign look_be = (q_valid && (q_addr == look_addr)) ? q_be : '0;
endmodule

// File: rtl/pipelined_store_cache.sv
module pipelined_store_cache #(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          idle_sel,
  input  logic                cpu_valid,
  output logic                cpu_ready,
  input  logic                cpu_we,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  input  logic [DATA_W/8-1:0] cpu_be,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_data,
  output logic                miss_valid,
  output logic [ADDR_W-1:0]   miss_addr,
  input  logic                fill_valid,
  input  logic [DATA_W-1:0]   fill_data
);
  import psc_pkg::*;

  localparam int BE_W  = DATA_W / 8;
  localparam int TAG_W = ADDR_W - INDEX_W;

  psc_state_e state;

  logic              accept, lk_hit, ld_hit, st_hit, miss_start, fill_we;
  logic [BE_W-1:0]   look_be, wb_be, fwd_be_q;
  logic              wb_valid, wb_retire, wb_push, wb_flush;
  logic [INDEX_W-1:0] wb_idx;
  logic [DATA_W-1:0] wb_data, fwd_data_q, ram_q, ld_merged;
  logic              ld_q;

  logic              pend_we;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_wdata;
  logic [BE_W-1:0]   pend_be;

  logic              ram_we;
  logic [INDEX_W-1:0] ram_widx;
  logic [DATA_W-1:0] ram_wdata;
  logic [BE_W-1:0]   ram_wbe;

  assign accept     = cpu_valid && cpu_ready;
  assign ld_hit     = accept && !cpu_we && lk_hit;
  assign st_hit     = accept && cpu_we && lk_hit;
  assign miss_start = accept && !lk_hit;
  assign fill_we    = (state == ST_WAIT) && fill_valid;
  assign wb_push    = st_hit || (fill_we && pend_we);
  assign wb_flush   = (state == ST_DRAIN);

  psc_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst),
    .lk_idx(cpu_addr[INDEX_W-1:0]), .lk_tag(cpu_addr[ADDR_W-1:INDEX_W]),
    .lk_hit(lk_hit),
    .wr_en(fill_we), .wr_idx(pend_addr[INDEX_W-1:0]),
    .wr_tag(pend_addr[ADDR_W-1:INDEX_W])
  );

  psc_write_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_W(INDEX_W)) u_wbuf (
    .clk(clk), .rst(rst), .idle_sel(idle_sel),
    .push(wb_push),
    .push_addr(fill_we ? pend_addr : cpu_addr),
    .push_data(fill_we ? pend_wdata : cpu_wdata),
    .push_be(fill_we ? pend_be : cpu_be),
    .flush(wb_flush), .look_addr(cpu_addr), .look_be(look_be),
    .q_valid(wb_valid), .q_idx(wb_idx), .q_data(wb_data), .q_be(wb_be),
    .retire(wb_retire)
  );

  // array write: refill word, or the pending store being released
  always_comb begin
    ram_we    = fill_we || wb_retire;
    ram_widx  = fill_we ? pend_addr[INDEX_W-1:0] : wb_idx;
    ram_wdata = fill_we ? fill_data : wb_data;
    ram_wbe   = fill_we ? {BE_W{1'b1}} : wb_be;
  end

  psc_data_ram #(.INDEX_W(INDEX_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .rd_en(ld_hit), .rd_idx(cpu_addr[INDEX_W-1:0]), .rd_data(ram_q),
    .wr_en(ram_we), .wr_idx(ram_widx), .wr_data(ram_wdata), .wr_be(ram_wbe)
  );

  // forwarding snapshot taken with the load's tag check
  always_ff @(posedge clk) begin
    if (rst) begin
      ld_q     <= 1'b0;
      fwd_be_q <= '0;
    end else begin
      ld_q     <= ld_hit;
      fwd_be_q <= look_be;
    end
    fwd_data_q <= wb_data;
  end

  for (genvar b = 0; b < BE_W; b++) begin : g_merge
    assign ld_merged[b*8 +: 8] = fwd_be_q[b] ? fwd_data_q[b*8 +: 8] : ram_q[b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= ld_q || (fill_we && !pend_we);
    end
    if (ld_q) rsp_data <= ld_merged;
    else if (fill_we) rsp_data <= fill_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_RUN;
      cpu_ready  <= 1'b1;
      miss_valid <= 1'b0;
    end else begin
      case (state)
        ST_RUN: if (miss_start) begin
          state     <= ST_DRAIN;
          cpu_ready <= 1'b0;
        end
        ST_DRAIN: begin
          state      <= ST_WAIT;
          miss_valid <= 1'b1;
        end
        ST_WAIT: if (fill_valid) begin
          state      <= ST_RUN;
          cpu_ready  <= 1'b1;
          miss_valid <= 1'b0;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (miss_start) begin
      pend_we    <= cpu_we;
      pend_addr  <= cpu_addr;
      pend_wdata <= cpu_wdata;
      pend_be    <= cpu_be;
    end
  end

  assign miss_addr = pend_addr;
endmodule

// File: rtl/pipelined_store_cache_chk.sv
module pipelined_store_cache_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] idle_sel,
  input logic       cpu_valid,
  input logic       cpu_ready,
  input logic       cpu_we,
  input logic       miss_valid,
  input logic       fill_valid,
  input logic       buf_valid,
  input logic       buf_retire,
  input logic       fill_we
);
  logic [2:0] idle_run;

  always_ff @(posedge clk) begin
    if (rst) idle_run <= '0;
    else if (buf_valid && !(cpu_valid && cpu_ready && cpu_we))
      idle_run <= (idle_run == 3'd7) ? idle_run : idle_run + 3'd1;
    else idle_run <= '0;
  end

  assert_stall_in_miss_R5: assert property (@(posedge clk) disable iff (rst)
    miss_valid |-> !cpu_ready);

  assert_miss_held_R5: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && !fill_valid) |=> miss_valid);

  assert_drained_in_miss_R5: assert property (@(posedge clk) disable iff (rst)
    miss_valid |-> !buf_valid);

  assert_idle_release_R8: assert property (@(posedge clk) disable iff (rst)
    buf_valid |-> (idle_run <= {1'b0, idle_sel}));

  assert_single_write_R9: assert property (@(posedge clk) disable iff (rst)
    !(fill_we && buf_retire));
endmodule

bind pipelined_store_cache pipelined_store_cache_chk u_chk (
  .clk(clk), .rst(rst), .idle_sel(idle_sel),
  .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
  .miss_valid(miss_valid), .fill_valid(fill_valid),
  .buf_valid(wb_valid), .buf_retire(wb_retire), .fill_we(fill_we)
);

// File: tb/sim_pipelined_store_cache.sv
`timescale 1ns/1ps
module sim_pipelined_store_cache;
  localparam int AW = 10, DW = 32, IW = 4, BW = DW/8, LN = 1 << IW;

  logic clk = 0, rst = 1;
  logic [1:0] idle_sel = 2'd1;
  logic cpu_valid = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [BW-1:0] cpu_be = '0;
  logic cpu_ready, rsp_valid, miss_valid;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] miss_addr;
  logic fill_valid = 0;
  logic [DW-1:0] fill_data = '0;

  always #2 clk = ~clk;

  pipelined_store_cache #(.ADDR_W(AW), .DATA_W(DW), .INDEX_W(IW)) u0 (.*);

  int checks = 0, fails = 0;
  string cur_r = "R1";
  logic [DW-1:0] exp_q[$];
  logic [AW-1:0] miss_q[$];
  bit       m_ok [LN];
  logic [AW-IW-1:0] m_tag [LN];
  logic [DW-1:0] m_dat [LN];

  function automatic logic [DW-1:0] nl_word(input logic [AW-1:0] a);
    return 32'hA5C30000 ^ ({22'd0, a} * 32'h00010101) ^ 32'h00001357;
  endfunction

  task automatic check(input string r, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // line-level model: direct mapped, one word per line, no write-back
  task automatic model(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [BW-1:0] be, output logic [DW-1:0] val, output bit miss);
    int i = int'(a[IW-1:0]);
    miss = !(m_ok[i] && m_tag[i] == a[AW-1:IW]);
    if (miss) begin
      m_ok[i] = 1; m_tag[i] = a[AW-1:IW]; m_dat[i] = nl_word(a);
    end
    if (we) for (int b = 0; b < BW; b++) if (be[b]) m_dat[i][b*8 +: 8] = d[b*8 +: 8];
    val = m_dat[i];
  endtask

  task automatic issue(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [BW-1:0] be, output bit stalled, output bit miss);
    logic [DW-1:0] v;
    @(negedge clk);
    stalled = 0;
    while (!cpu_ready) begin stalled = 1; cpu_valid = 0; @(negedge clk); end
    cpu_valid = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be;
    model(we, a, d, be, v, miss);
    if (!we) exp_q.push_back(v);
    if (miss) miss_q.push_back(a);
    @(posedge clk);
  endtask

  task automatic quiet(input int n);
    for (int k = 0; k < n; k++) begin @(negedge clk); cpu_valid = 0; end
  endtask

  task automatic settle();
    quiet(1);
    while (exp_q.size() != 0 || !cpu_ready || miss_valid) quiet(1);
    quiet(2);
  endtask

  // refill responder: answers each request after a short delay
  initial begin
    int wc = 0;
    forever begin
      @(negedge clk);
      if (fill_valid) fill_valid = 0;
      else if (miss_valid) begin
        if (wc == 2) begin
          if (miss_q.size() == 0) check("R5 unexpected miss", {22'd0, miss_addr}, '1);
          else check("R5 miss_addr", {22'd0, miss_addr}, {22'd0, miss_q.pop_front()});
          fill_data = nl_word(miss_addr); fill_valid = 1; wc = 0;
        end else wc++;
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && rsp_valid) begin
        if (exp_q.size() == 0) check({cur_r, " spurious rsp"}, rsp_data, 'x);
        else check({cur_r, " load data"}, rsp_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit st, ms, any_stall;
    for (int i = 0; i < LN; i++) m_ok[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    check("R1 cpu_ready", {31'd0, cpu_ready}, 1);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 0);
    check("R1 miss_valid", {31'd0, miss_valid}, 0);

    // R1/R6: first load misses, fill word returned, port stalls
    cur_r = "R6";
    issue(0, 10'h005, 0, 0, st, ms);
    check("R1 first access misses", {31'd0, ms}, 1);
    @(negedge clk); cpu_valid = 0;
    check("R5 ready low after miss", {31'd0, cpu_ready}, 0);
    settle();

    // R2: hit latency
    cur_r = "R2";
    issue(0, 10'h005, 0, 0, st, ms);
    @(negedge clk); cpu_valid = 0;
    check("R2 rsp_valid after one edge", {31'd0, rsp_valid}, 0);
    @(negedge clk);
    check("R2 rsp_valid after two edges", {31'd0, rsp_valid}, 1);
    settle();

    // warm four lines, then back-to-back stores (R3) and loads
    cur_r = "R3";
    for (int k = 0; k < 4; k++) issue(0, 10'h010 + 10'(k), 0, 0, st, ms);
    settle();
    any_stall = 0;
    for (int k = 0; k < 4; k++) begin
      issue(1, 10'h010 + 10'(k), 32'h11223344 * (k + 1), 4'hF >> k, st, ms);
      any_stall |= st;
    end
    check("R3 back-to-back stores without stall", {31'd0, any_stall}, 0);
    for (int k = 0; k < 4; k++) issue(0, 10'h010 + 10'(k), 0, 0, st, ms);
    settle();

    // R4/R10: partial store then immediate load from pending entry
    cur_r = "R4";
    issue(1, 10'h011, 32'hDEADBEEF, 4'b0101, st, ms);
    issue(0, 10'h011, 0, 0, st, ms);
    cur_r = "R10";
    issue(1, 10'h012, 32'hCAFE0000, 4'b1000, st, ms);
    issue(0, 10'h012, 0, 0, st, ms);
    settle();

    // R7: store miss then load
    cur_r = "R7";
    issue(1, 10'h020 + 10'h007, 32'h0BADF00D, 4'b0011, st, ms);
    check("R7 store misses", {31'd0, ms}, 1);
    issue(0, 10'h027, 0, 0, st, ms);
    settle();

    // R8: each idle setting, store then long gap then load
    cur_r = "R8";
    for (int s = 0; s < 4; s++) begin
      settle();
      idle_sel = 2'(s);
      issue(1, 10'h013, 32'h5A5A0000 + s, 4'b1111, st, ms);
      quiet(s + 3);
      issue(0, 10'h013, 0, 0, st, ms);
      issue(1, 10'h010, 32'h77000000 + s, 4'b0110, st, ms);
      quiet(s);
      issue(0, 10'h010, 0, 0, st, ms);
    end
    settle();

    // R5: conflict eviction with a pending store in the same line
    cur_r = "R5";
    issue(1, 10'h015, 32'h01020304, 4'hF, st, ms);
    issue(0, 10'h035, 0, 0, st, ms);
    check("R5 conflicting load misses", {31'd0, ms}, 1);
    issue(0, 10'h015, 0, 0, st, ms);
    settle();

    // mixed traffic across R2/R3/R4/R9
    cur_r = "R9";
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a = 10'($urandom_range(0, 47));
      bit w = ($urandom_range(0, 1) == 1);
      issue(w, a, $urandom, 4'($urandom), st, ms);
      if ($urandom_range(0, 3) == 0) quiet($urandom_range(1, 5));
    end
    settle();
    check("R2 all responses delivered", exp_q.size(), 0);
    check("R5 all misses served", miss_q.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule